// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is the 8-bit arithmetic and logic unit of a small accumulator-style processor core. Each clock cycle it takes a decoded operation code, the working-register value and a second operand, which is either the addressed file register or an immediate constant. It produces a result and updates a three-bit status word holding carry, nibble carry and zero. The rules for updating each flag depend on the operation.

The status word is held inside the block, so operations that must leave a flag alone keep its previous value. Rotates read the stored carry. A destination bit steers the result: it is either written back into the working register or into the file register, through one of two write strobes. The increment-and-decrement-with-skip operations raise a skip output that the sequencer uses to discard the next instruction.

All outputs are registered. An operation presented before a rising edge shows its result, its strobes, its skip and its new status after that edge.

Top module: `acc_alu`

## Requirements
- R1: While `rst` is high at a rising edge, `result_o`, `status_o`, `w_we_o`, `f_we_o` and `skip_o` become 0. Otherwise each operation presented at an edge is reflected on the outputs just after that edge.
- R2: Operation codes on `op_i`: 0 NOP, 1 MOVE, 2 MOVW, 3 CLR, 4 ADD, 5 SUB, 6 AND, 7 IOR, 8 XOR, 9 COM, 10 INC, 11 DEC, 12 INCSZ, 13 DECSZ, 14 RL, 15 RR, 16 SWAP, 17 SETC, 18 CLRC, 19 SETDC, 20 CLRDC, 21 SETZ, 22 CLRZ. Codes 23 to 31 behave as NOP. Operand B is `lit_i` when `use_lit_i` is 1 and `f_i` otherwise. `status_o` bit 0 is carry, bit 1 is nibble carry and bit 2 is zero.
- R3: ADD yields W+B. Carry is the carry out of bit 7, nibble carry is the carry out of bit 3, and zero is set when the result is 0.
- R4: SUB yields B-W. Carry is 1 when no borrow leaves bit 7, nibble carry is 1 when no borrow leaves bit 3, and zero is set when the result is 0.
- R5: AND, IOR and XOR combine W with B, and COM inverts B. These four update only zero; carry and nibble carry keep their values.
- R6: RL shifts B left with the old carry entering bit 0 and bit 7 becoming the new carry. RR shifts B right with the old carry entering bit 7 and bit 0 becoming the new carry. Zero and nibble carry keep their values.
- R7: SWAP exchanges the two nibbles of B, and MOVW passes W. Neither changes any flag.
- R8: CLR yields 0 and sets zero. MOVE passes B and sets zero exactly when B is 0.
- R9: INC and DEC yield B+1 and B-1 with 8-bit wraparound. They update zero and leave carry and nibble carry unchanged.
- R10: INCSZ and DECSZ yield B+1 and B-1 and change no flag. `skip_o` is 1 exactly when such an operation gives 0, and it is 0 after every other operation.
- R11: A writing operation with `dest_i`=0 raises `w_we_o`, and with `dest_i`=1 it raises `f_we_o`. NOP and the six flag operations raise neither.
- R12: Each of SETC, CLRC, SETDC, CLRDC, SETZ and CLRZ forces only its own status bit. After NOP or any flag operation, `result_o` holds its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 5 | Decoded operation code |
| w_i | input | 8 | Working-register operand |
| f_i | input | 8 | File-register operand |
| lit_i | input | 8 | Immediate operand |
| use_lit_i | input | 1 | Select immediate as operand B |
| dest_i | input | 1 | 0 routes result to W, 1 to file register |
| result_o | output | 8 | Registered result |
| w_we_o | output | 1 | Write strobe for the working register |
| f_we_o | output | 1 | Write strobe for the file register |
| status_o | output | 3 | Status word {zero, nibble carry, carry} |
| skip_o | output | 1 | Skip request from INCSZ/DECSZ |

## Verification
The bench goes after the borrow polarity of subtraction, using 0x80-1 and 0x80-0. A design that treated carry as a borrow, or derived nibble carry from the wrong stage, would invert C or DC in those cases. It wraps 0xFF through ADD, INC and INCSZ with carry preset, which exposes an increment that leaks its adder carry into the status word or that updates zero during a skip operation. It also rotates with zero and carry held at opposite values to catch a rotate that disturbs zero or ignores the old carry. Finally it checks that logic, swap and flag operations leave the untouched bits and the result register exactly as they were.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

  typedef enum logic [4:0] {
    OP_NOP   = 5'd0,
    OP_MOVE  = 5'd1,
    OP_MOVW  = 5'd2,
    OP_CLR   = 5'd3,
    OP_ADD   = 5'd4,
    OP_SUB   = 5'd5,
    OP_AND   = 5'd6,
    OP_IOR   = 5'd7,
    OP_XOR   = 5'd8,
    OP_COM   = 5'd9,
    OP_INC   = 5'd10,
    OP_DEC   = 5'd11,
    OP_INCSZ = 5'd12,
    OP_DECSZ = 5'd13,
    OP_RL    = 5'd14,
    OP_RR    = 5'd15,
    OP_SWAP  = 5'd16,
    OP_SETC  = 5'd17,
    OP_CLRC  = 5'd18,
    OP_SETDC = 5'd19,
    OP_CLRDC = 5'd20,
    OP_SETZ  = 5'd21,
    OP_CLRZ  = 5'd22
  } alu_op_e;

  localparam int ST_C     = 0;
  localparam int ST_DC    = 1;
  localparam int ST_Z     = 2;
  localparam int ST_WIDTH = 3;

  // Operations served by the shared adder
  function automatic logic uses_adder(input alu_op_e op);
    return op inside {OP_ADD, OP_SUB, OP_INC, OP_DEC, OP_INCSZ, OP_DECSZ};
  endfunction

  // Operations that produce a result to be written back
  function automatic logic writes_back(input logic [4:0] code);
    return (code != 5'(OP_NOP)) && (code < 5'(OP_SETC));
  endfunction

endpackage

// File: rtl/acc_alu_arith.sv
module acc_alu_arith
  import acc_alu_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int NIB   = WIDTH / 2
) (
  input  alu_op_e            op,
  input  logic [WIDTH-1:0]   a_w,
  input  logic [WIDTH-1:0]   b_op,
  output logic [WIDTH-1:0]   sum,
  output logic               c_out,
  output logic               dc_out
);

  logic [WIDTH-1:0] addend;
  logic             cin;
  logic [WIDTH:0]   full;
  logic [NIB:0]     low;

  // Every arithmetic operation is B + addend + cin
  always_comb begin
    addend = '0;
    cin    = 1'b0;
    case (op)
      OP_ADD:            begin addend = a_w;  cin = 1'b0; end
      OP_SUB:            begin addend = ~a_w; cin = 1'b1; end
      OP_INC, OP_INCSZ:  begin addend = '0;   cin = 1'b1; end
      OP_DEC, OP_DECSZ:  begin addend = '1;   cin = 1'b0; end
      default:           begin addend = '0;   cin = 1'b0; end
    endcase
  end

  assign full   = {1'b0, b_op} + {1'b0, addend} + (WIDTH+1)'(cin);
  assign low    = {1'b0, b_op[NIB-1:0]} + {1'b0, addend[NIB-1:0]} + (NIB+1)'(cin);
  assign sum    = full[WIDTH-1:0];
  assign c_out  = full[WIDTH];
  assign dc_out = low[NIB];

endmodule

// File: rtl/acc_alu_logic.sv
module acc_alu_logic
  import acc_alu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  alu_op_e            op,
  input  logic [WIDTH-1:0]   a_w,
  input  logic [WIDTH-1:0]   b_op,
  input  logic               c_in,
  output logic [WIDTH-1:0]   res,
  output logic               c_out
);

  localparam int HALF = WIDTH / 2;

  logic [WIDTH-1:0] swapped;

  // Exchange the halves bit by bit
  for (genvar i = 0; i < WIDTH; i++) begin : g_swap
    assign swapped[i] = b_op[(i + HALF) % WIDTH];
  end

  always_comb begin
    res   = '0;
    c_out = c_in;
    case (op)
      OP_AND:  res = a_w & b_op;
      OP_IOR:  res = a_w | b_op;
      OP_XOR:  res = a_w ^ b_op;
      OP_COM:  res = ~b_op;
      OP_MOVE: res = b_op;
      OP_MOVW: res = a_w;
      OP_CLR:  res = '0;
      OP_SWAP: res = swapped;
      OP_RL: begin
        res   = {b_op[WIDTH-2:0], c_in};
        c_out = b_op[WIDTH-1];
      end
      OP_RR: begin
        res   = {c_in, b_op[WIDTH-1:1]};
        c_out = b_op[0];
      end
      default: res = '0;
    endcase
  end

endmodule

// File: rtl/acc_alu_flags.sv
module acc_alu_flags
  import acc_alu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  alu_op_e              op,
  input  logic [WIDTH-1:0]     result,
  input  logic                 add_c,
  input  logic                 add_dc,
  input  logic                 rot_c,
  output logic [ST_WIDTH-1:0]  status_q
);

  logic                zero;
  logic [ST_WIDTH-1:0] base;
  logic [ST_WIDTH-1:0] nxt;

  assign zero = (result == '0);

  // Per-operation update of the status word
  always_comb begin
    base = status_q;
    case (op)
      OP_ADD, OP_SUB: begin
        base[ST_C]  = add_c;
        base[ST_DC] = add_dc;
        base[ST_Z]  = zero;
      end
      OP_INC, OP_DEC, OP_AND, OP_IOR, OP_XOR,
      OP_COM, OP_MOVE, OP_CLR:
        base[ST_Z] = zero;
      OP_RL, OP_RR:
        base[ST_C] = rot_c;
      default: base = status_q;
    endcase
  end

  // Force operations: bit i is set by SETC+2i and cleared by SETC+2i+1
  for (genvar i = 0; i < ST_WIDTH; i++) begin : g_force
    localparam logic [4:0] SET_CODE = 5'(int'(OP_SETC) + 2 * i);
    localparam logic [4:0] CLR_CODE = 5'(int'(OP_SETC) + 2 * i + 1);
    always_comb begin
      if (op == alu_op_e'(SET_CODE))      nxt[i] = 1'b1;
      else if (op == alu_op_e'(CLR_CODE)) nxt[i] = 1'b0;
      else                                nxt[i] = base[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) status_q <= '0;
    else     status_q <= nxt;
  end

endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [4:0]         op_i,
  input  logic [WIDTH-1:0]   w_i,
  input  logic [WIDTH-1:0]   f_i,
  input  logic [WIDTH-1:0]   lit_i,
  input  logic               use_lit_i,
  input  logic               dest_i,
  output logic [WIDTH-1:0]   result_o,
  output logic               w_we_o,
  output logic               f_we_o,
  output logic [2:0]         status_o,
  output logic               skip_o
);

  localparam int NIB = WIDTH / 2;

  alu_op_e          op;
  logic [WIDTH-1:0] b_op;
  logic [WIDTH-1:0] add_res;
  logic [WIDTH-1:0] log_res;
  logic [WIDTH-1:0] res;
  logic             add_c;
  logic             add_dc;
  logic             rot_c;
  logic             wr;
  logic             skip_d;
  logic [ST_WIDTH-1:0] status_q;

  // Unused codes map onto NOP
  assign op   = (op_i > 5'(OP_CLRZ)) ? OP_NOP : alu_op_e'(op_i);
  assign b_op = use_lit_i ? lit_i : f_i;

  acc_alu_arith #(.WIDTH(WIDTH), .NIB(NIB)) u_arith (
    .op     (op),
    .a_w    (w_i),
    .b_op   (b_op),
    .sum    (add_res),
    .c_out  (add_c),
    .dc_out (add_dc)
  );

  acc_alu_logic #(.WIDTH(WIDTH)) u_logic (
    .op    (op),
    .a_w   (w_i),
    .b_op  (b_op),
    .c_in  (status_q[ST_C]),
    .res   (log_res),
    .c_out (rot_c)
  );

  assign res    = uses_adder(op) ? add_res : log_res;
  assign wr     = writes_back(5'(op));
  assign skip_d = (op inside {OP_INCSZ, OP_DECSZ}) && (add_res == '0);

  acc_alu_flags #(.WIDTH(WIDTH)) u_flags (
    .clk      (clk),
    .rst      (rst),
    .op       (op),
    .result   (res),
    .add_c    (add_c),
    .add_dc   (add_dc),
    .rot_c    (rot_c),
    .status_q (status_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result_o <= '0;
      w_we_o   <= 1'b0;
      f_we_o   <= 1'b0;
      skip_o   <= 1'b0;
    end else begin
      if (wr) result_o <= res;
      w_we_o <= wr & ~dest_i;
      f_we_o <= wr & dest_i;
      skip_o <= skip_d;
    end
  end

  assign status_o = status_q;

endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk
  import acc_alu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [4:0]       op_i,
  input logic [WIDTH-1:0] result_o,
  input logic             w_we_o,
  input logic             f_we_o,
  input logic [2:0]       status_o,
  input logic             skip_o
);

  assert_add_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (op_i == 5'(OP_ADD)) |=> (status_o[ST_Z] == (result_o == '0)));

  assert_logic_keeps_carries_R5: assert property (@(posedge clk) disable iff (rst)
    (op_i inside {5'(OP_AND), 5'(OP_IOR), 5'(OP_XOR), 5'(OP_COM)})
      |=> (status_o[1:0] == $past(status_o[1:0])));

  assert_rotate_keeps_z_dc_R6: assert property (@(posedge clk) disable iff (rst)
    (op_i inside {5'(OP_RL), 5'(OP_RR)}) |=> (status_o[2:1] == $past(status_o[2:1])));

  assert_swap_movw_flags_R7: assert property (@(posedge clk) disable iff (rst)
    (op_i inside {5'(OP_SWAP), 5'(OP_MOVW)}) |=> $stable(status_o));

  assert_clear_R8: assert property (@(posedge clk) disable iff (rst)
    (op_i == 5'(OP_CLR)) |=> (result_o == '0 && status_o[ST_Z]));

  assert_skip_source_R10: assert property (@(posedge clk) disable iff (rst)
    !(op_i inside {5'(OP_INCSZ), 5'(OP_DECSZ)}) |=> !skip_o);

  assert_skipops_flags_R10: assert property (@(posedge clk) disable iff (rst)
    (op_i inside {5'(OP_INCSZ), 5'(OP_DECSZ)}) |=> $stable(status_o));

  assert_nop_no_write_R11: assert property (@(posedge clk) disable iff (rst)
    (op_i == 5'(OP_NOP)) |=> (!w_we_o && !f_we_o && $stable(result_o)));

  assert_one_strobe_R11: assert property (@(posedge clk) disable iff (rst)
    $onehot0({w_we_o, f_we_o}));

  assert_setc_R12: assert property (@(posedge clk) disable iff (rst)
    (op_i == 5'(OP_SETC)) |=> (status_o[ST_C] && $stable(status_o[2:1])));

endmodule

bind acc_alu acc_alu_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/tb_acc_alu.sv
module tb_acc_alu;

  // Operation codes as given in R2
  localparam logic [4:0] NOP = 0, MOVE = 1, MOVW = 2, CLR = 3, ADD = 4, SUB = 5,
    AND = 6, IOR = 7, XOR = 8, COM = 9, INC = 10, DEC = 11, INCSZ = 12,
    DECSZ = 13, RL = 14, RR = 15, SWAP = 16, SETC = 17, CLRC = 18,
    SETDC = 19, CLRDC = 20, SETZ = 21, CLRZ = 22;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] op_i = NOP;
  logic [7:0] w_i = '0, f_i = '0, lit_i = '0;
  logic       use_lit_i = 1'b0, dest_i = 1'b0;
  logic [7:0] result_o;
  logic       w_we_o, f_we_o, skip_o;
  logic [2:0] status_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  acc_alu dut (
    .clk(clk), .rst(rst), .op_i(op_i), .w_i(w_i), .f_i(f_i), .lit_i(lit_i),
    .use_lit_i(use_lit_i), .dest_i(dest_i), .result_o(result_o),
    .w_we_o(w_we_o), .f_we_o(f_we_o), .status_o(status_o), .skip_o(skip_o)
  );

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0h expected %0h", tag, got, exp);
    end
  endtask

  // Expected status as {z, dc, c}
  task automatic chk_st(input string tag, input bit c, input bit dc, input bit z);
    chk(tag, int'(status_o), int'({z, dc, c}));
  endtask

  // Drive at the falling edge, sample 1 ns after the next rising edge
  task automatic run(input logic [4:0] op, input logic [7:0] w, input logic [7:0] f,
                     input logic dst = 1'b0, input logic ul = 1'b0,
                     input logic [7:0] lit = 8'h00);
    @(negedge clk);
    op_i = op; w_i = w; f_i = f; dest_i = dst; use_lit_i = ul; lit_i = lit;
    @(posedge clk);
    #1;
    op_i = NOP;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 result", result_o, 0);
    chk("R1 status", status_o, 0);
    chk("R1 strobes", {w_we_o, f_we_o, skip_o}, 0);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_add();
    run(ADD, 8'h88, 8'h88); chk("R3 88+88", result_o, 8'h10); chk_st("R3 88+88 flags", 1, 1, 0);
    run(ADD, 8'h80, 8'h80); chk("R3 80+80", result_o, 8'h00); chk_st("R3 80+80 flags", 1, 0, 1);
    run(ADD, 8'h00, 8'h00); chk_st("R3 0+0 flags", 0, 0, 1);
    run(ADD, 8'hFF, 8'h01); chk("R3 FF+1", result_o, 0); chk_st("R3 FF+1 flags", 1, 1, 1);
    run(ADD, 8'h05, 8'hEE, 1'b0, 1'b1, 8'h0A);
    chk("R3 literal", result_o, 8'h0F); chk_st("R3 literal flags", 0, 0, 0);
  endtask

  task automatic t_sub();
    run(SUB, 8'h00, 8'h00); chk("R4 0-0", result_o, 0);    chk_st("R4 0-0 flags", 1, 1, 1);
    run(SUB, 8'h01, 8'h00); chk("R4 0-1", result_o, 8'hFF); chk_st("R4 0-1 flags", 0, 0, 0);
    run(SUB, 8'h01, 8'h80); chk("R4 80-1", result_o, 8'h7F); chk_st("R4 80-1 flags", 1, 0, 0);
    run(SUB, 8'h00, 8'h80); chk("R4 80-0", result_o, 8'h80); chk_st("R4 80-0 flags", 1, 1, 0);
    run(SUB, 8'h03, 8'h99, 1'b0, 1'b1, 8'h10);
    chk("R4 literal", result_o, 8'h0D); chk_st("R4 literal flags", 1, 0, 0);
  endtask

  task automatic t_logic();
    run(SETC, 0, 0); run(SETDC, 0, 0);
    run(AND, 8'h01, 8'h00); chk("R5 and", result_o, 0);    chk_st("R5 and flags", 1, 1, 1);
    run(XOR, 8'hFF, 8'h00); chk("R5 xor", result_o, 8'hFF); chk_st("R5 xor flags", 1, 1, 0);
    run(IOR, 8'h00, 8'h00); chk("R5 ior", result_o, 0);    chk_st("R5 ior flags", 1, 1, 1);
    run(COM, 8'h00, 8'hFF); chk("R5 com", result_o, 0);    chk_st("R5 com flags", 1, 1, 1);
    run(CLRC, 0, 0); run(CLRDC, 0, 0);
    run(AND, 8'hF0, 8'h3C); chk("R5 and 30", result_o, 8'h30); chk_st("R5 and 30 flags", 0, 0, 0);
  endtask

  task automatic t_rotate();
    run(SETZ, 0, 0); run(CLRDC, 0, 0); run(SETC, 0, 0);
    run(RL, 0, 8'h80); chk("R6 rl 80", result_o, 8'h01); chk_st("R6 rl 80 flags", 1, 0, 1);
    run(RL, 0, 8'h00); chk("R6 rl cin", result_o, 8'h01); chk_st("R6 rl cin flags", 0, 0, 1);
    run(CLRZ, 0, 0);
    run(RR, 0, 8'h01); chk("R6 rr 01", result_o, 8'h00); chk_st("R6 rr 01 flags", 1, 0, 0);
    run(RR, 0, 8'h00); chk("R6 rr cin", result_o, 8'h80); chk_st("R6 rr cin flags", 0, 0, 0);
  endtask

  task automatic t_swap();
    run(SETC, 0, 0); run(SETDC, 0, 0); run(CLRZ, 0, 0);
    run(SWAP, 0, 8'h0F); chk("R7 swap 0F", result_o, 8'hF0); chk_st("R7 swap flags", 1, 1, 0);
    run(SWAP, 0, 8'h00); chk("R7 swap 00", result_o, 0);    chk_st("R7 swap zero flags", 1, 1, 0);
    run(MOVW, 8'h5A, 8'h11, 1'b1);
    chk("R7 movw", result_o, 8'h5A); chk_st("R7 movw flags", 1, 1, 0);
  endtask

  task automatic t_clear_move();
    run(CLRZ, 0, 0);
    run(CLR, 8'h77, 8'h66, 1'b1); chk("R8 clr", result_o, 0); chk("R8 clr z", status_o[2], 1);
    run(MOVE, 0, 8'h01); chk("R8 move 01", result_o, 1); chk("R8 move 01 z", status_o[2], 0);
    run(MOVE, 8'h44, 8'h00); chk("R8 move 00", result_o, 0); chk("R8 move 00 z", status_o[2], 1);
  endtask

  task automatic t_incdec();
    run(SETC, 0, 0); run(CLRDC, 0, 0);
    run(INC, 0, 8'hFF); chk("R9 inc FF", result_o, 0); chk_st("R9 inc FF flags", 1, 0, 1);
    chk("R9 inc no skip", skip_o, 0);
    run(INC, 0, 8'h7F); chk("R9 inc 7F", result_o, 8'h80); chk_st("R9 inc 7F flags", 1, 0, 0);
    run(DEC, 0, 8'h01); chk("R9 dec 01", result_o, 0);    chk_st("R9 dec 01 flags", 1, 0, 1);
    run(DEC, 0, 8'h00); chk("R9 dec 00", result_o, 8'hFF); chk_st("R9 dec 00 flags", 1, 0, 0);
  endtask

  task automatic t_skip();
    run(CLRZ, 0, 0);
    run(INCSZ, 0, 8'hFF); chk("R10 incsz FF", result_o, 0); chk("R10 skip", skip_o, 1);
    chk("R10 incsz z kept", status_o[2], 0);
    run(INCSZ, 0, 8'h01); chk("R10 incsz 01", result_o, 2); chk("R10 no skip", skip_o, 0);
    run(SETZ, 0, 0);
    run(DECSZ, 0, 8'h02); chk("R10 decsz 02", result_o, 1); chk("R10 decsz no skip", skip_o, 0);
    chk("R10 decsz z kept", status_o[2], 1);
    run(DECSZ, 0, 8'h01); chk("R10 decsz 01", result_o, 0); chk("R10 decsz skip", skip_o, 1);
    run(NOP, 0, 0); chk("R10 skip drops", skip_o, 0);
  endtask

  task automatic t_dest();
    run(ADD, 8'h01, 8'h02, 1'b0);
    chk("R11 dest W", {w_we_o, f_we_o}, 2'b10); chk("R11 result", result_o, 3);
    run(ADD, 8'h01, 8'h04, 1'b1); chk("R11 dest F", {w_we_o, f_we_o}, 2'b01);
    run(NOP, 8'hAA, 8'hAA, 1'b1);
    chk("R11 nop strobes", {w_we_o, f_we_o}, 0); chk("R12 nop result hold", result_o, 5);
    run(SETC, 8'hAA, 8'hAA, 1'b1); chk("R11 flag op strobes", {w_we_o, f_we_o}, 0);
    run(5'd31, 8'h12, 8'h34, 1'b1);
    chk("R2 unused code strobes", {w_we_o, f_we_o}, 0); chk("R2 unused code result", result_o, 5);
  endtask

  task automatic t_flags();
    run(MOVE, 0, 8'h3C);
    run(CLRC, 0, 0); run(CLRDC, 0, 0); run(CLRZ, 0, 0); chk("R12 all clear", status_o, 0);
    run(SETDC, 0, 0); chk("R12 setdc", status_o, 3'b010);
    run(SETZ, 0, 0);  chk("R12 setz", status_o, 3'b110);
    run(SETC, 0, 0);  chk("R12 setc", status_o, 3'b111);
    run(CLRDC, 0, 0); chk("R12 clrdc", status_o, 3'b101);
    run(CLRZ, 0, 0);  chk("R12 clrz", status_o, 3'b001);
    run(CLRC, 0, 0);  chk("R12 clrc", status_o, 3'b000);
    chk("R12 result hold", result_o, 8'h3C);
  endtask

  initial begin
    t_reset();
    t_add();
    t_sub();
    t_logic();
    t_rotate();
    t_swap();
    t_clear_move();
    t_incdec();
    t_skip();
    t_dest();
    t_flags();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired got 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule